// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits on the access side of a 32K x 8 memory that has a nonvolatile shadow. It watches the stream of read cycles. It recognises two hidden commands, each written as a fixed run of six reads at particular addresses. The first five addresses are the same for both commands. The sixth address picks the operation: an image of the array is written into the nonvolatile cells (store), or the nonvolatile image is brought back into the array (recall).

When a command completes, the block emits a single-cycle start pulse. It then holds the memory busy for a duration set in clock cycles. While busy, the block refuses every access and does not track any sequence. A recall is shown as two phases in order: a clear phase, then a transfer phase.

A low-supply flag blocks all array writes and any store requested by the sequence. It does not block recall. Recall may be repeated without limit. Output enable plays no part in command recognition and only gates the data driver.

Top module: `seqdet_top`

## Requirements
- R1: Six reads at 0E38, 31C7, 03E0, 3C1F, 303F, 0FC0 (hex), in that order and with no write between them, produce `store_go` high for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth read, and `busy` rises in that same cycle. `store_go` and `recall_go` are never high together.
- R2: The same first five reads followed by a read at 0C63 produce a one-cycle `recall_go` pulse at the same timing. `clr_phase` rises together with it.
- R3: A cycle counts as a step only when `acc_en`=1 and `wr_en`=0. A cycle with `acc_en`=0 leaves the progress unchanged. A write (`acc_en`=1, `wr_en`=1) returns the progress to zero. The level of `oe_en` has no effect on recognition.
- R4: A read whose address is not the expected next address returns the progress to zero. If that address is 0E38, the progress becomes one step instead.
- R5: After a store start, `busy` stays high for exactly STORE_CYCLES cycles and `ready` is its inverse. While `busy` is high, accesses are refused (`rd_allow`=0, `wr_allow`=0) and reads do not advance any sequence.
- R6: After a recall start, `clr_phase` is high for CLEAR_CYCLES cycles. `xfer_phase` is then high for RECALL_CYCLES−CLEAR_CYCLES cycles. The two are never high together, and `busy` covers both.
- R7: While `low_vdd`=1, `wr_allow` stays 0. A completed store sequence then gives no pulse and no busy time, but a completed recall sequence is still honoured.
- R8: Recall may be started any number of times in succession. Each start behaves the same way.
- R9: Outside the busy time, `rd_allow` = `acc_en` & !`wr_en`, and `dq_drive` = `rd_allow` & `oe_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 15 | Access address |
| acc_en | input | 1 | Chip enabled: this cycle is an access |
| wr_en | input | 1 | Access is a write (0 = read) |
| oe_en | input | 1 | Output enable for the data driver |
| low_vdd | input | 1 | Low-supply condition |
| store_go | output | 1 | One-cycle store start |
| recall_go | output | 1 | One-cycle recall start |
| busy | output | 1 | Nonvolatile operation in progress |
| ready | output | 1 | Memory accessible |
| clr_phase | output | 1 | Recall clear phase |
| xfer_phase | output | 1 | Recall transfer phase |
| wr_allow | output | 1 | Write reaches the array |
| rd_allow | output | 1 | Read served by the array |
| dq_drive | output | 1 | Data output driver enable |

## Verification
On every cycle, the assertions check that the two start pulses are exclusive. They also check that a store pulse coincides with the rise of busy and never follows a low-supply cycle, that a write or a stray 0E38 read sets the progress to the value R3 and R4 give, and that the clear phase hands over directly to the transfer phase. The exact busy lengths, partial matches that interleave with restarts, sequences sent during busy time, and repeated recalls can only be shown by the bench's scenarios. The bench's reference model follows each of these cycle by cycle.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
    localparam int unsigned ADDR_W  = 15;
    localparam int unsigned SEQ_LEN = 6;
    localparam int unsigned PTR_W   = $clog2(SEQ_LEN);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STORE = 2'd1,
        PH_CLEAR = 2'd2,
        PH_XFER  = 2'd3
    } phase_e;

    // final address of each command; the shared prefix is in step_addr
    localparam addr_t STORE_TAIL  = 15'h0FC0;
    localparam addr_t RECALL_TAIL = 15'h0C63;

    function automatic addr_t step_addr(input logic [PTR_W-1:0] idx);
        addr_t a;
        case (idx)
            3'd0:    a = 15'h0E38;
            3'd1:    a = 15'h31C7;
            3'd2:    a = 15'h03E0;
            3'd3:    a = 15'h3C1F;
            default: a = 15'h303F;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker
    import seqdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t addr,
    input  logic  acc_en,
    input  logic  wr_en,
    input  logic  hold,
    output logic  hit_store,
    output logic  hit_recall
);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(SEQ_LEN - 1);
    localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);
    localparam addr_t            HEAD  = step_addr('0);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rd_step;

    assign rd_step = acc_en && !wr_en && !hold;

    always_comb begin
        trk_d      = trk_q;
        hit_store  = 1'b0;
        hit_recall = 1'b0;
        if (hold) begin
            trk_d.ptr = '0;
        end else if (acc_en) begin
            if (wr_en) begin
                trk_d.ptr = '0;
            end else if (trk_q.ptr == LAST) begin
                trk_d.ptr = (addr == HEAD) ? ONE : '0;
                if (addr == STORE_TAIL)       hit_store  = 1'b1;
                else if (addr == RECALL_TAIL) hit_recall = 1'b1;
            end else if (addr == step_addr(trk_q.ptr)) begin
                trk_d.ptr = trk_q.ptr + ONE;
            end else begin
                trk_d.ptr = (addr == HEAD) ? ONE : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R3
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en && !hold) |=> (trk_q.ptr == '0));

    // R4
    head_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && addr == HEAD) |=> (trk_q.ptr == ONE));

    // R5
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!hit_store && !hit_recall));
endmodule

// File: rtl/op_timer.sv
module op_timer
    import seqdet_pkg::*;
#(
    parameter int unsigned STORE_CYCLES  = 20,
    parameter int unsigned RECALL_CYCLES = 12,
    parameter int unsigned CLEAR_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_store,
    input  logic start_recall,
    output logic busy,
    output logic clr_phase,
    output logic xfer_phase
);
    localparam int unsigned MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_STORE = CNT_W'(STORE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_CLEAR = CNT_W'(CLEAR_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_XFER  = CNT_W'(RECALL_CYCLES - CLEAR_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.ph == PH_IDLE) begin
            if (start_store) begin
                tmr_d.ph  = PH_STORE;
                tmr_d.cnt = LD_STORE;
            end else if (start_recall) begin
                tmr_d.ph  = PH_CLEAR;
                tmr_d.cnt = LD_CLEAR;
            end
        end else if (tmr_q.cnt == '0) begin
            if (tmr_q.ph == PH_CLEAR) begin
                tmr_d.ph  = PH_XFER;
                tmr_d.cnt = LD_XFER;
            end else begin
                tmr_d.ph  = PH_IDLE;
            end
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '{ph: PH_IDLE, cnt: '0};
        else        tmr_q <= tmr_d;
    end

    assign busy       = (tmr_q.ph != PH_IDLE);
    assign clr_phase  = (tmr_q.ph == PH_CLEAR);
    assign xfer_phase = (tmr_q.ph == PH_XFER);

    // R6
    clear_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_phase) |-> xfer_phase);

    // R6
    xfer_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_phase) |-> $past(clr_phase));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_store || start_recall) |-> !busy);
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
    import seqdet_pkg::*;
#(
    parameter int unsigned STORE_CYCLES  = 20,
    parameter int unsigned RECALL_CYCLES = 12,
    parameter int unsigned CLEAR_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic              oe_en,
    input  logic              low_vdd,
    output logic              store_go,
    output logic              recall_go,
    output logic              busy,
    output logic              ready,
    output logic              clr_phase,
    output logic              xfer_phase,
    output logic              wr_allow,
    output logic              rd_allow,
    output logic              dq_drive
);
    typedef struct packed {
        logic store_go;
        logic recall_go;
    } pulse_t;

    pulse_t pls_d, pls_q;
    logic   hit_store, hit_recall;
    logic   start_store, start_recall;

    seq_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .acc_en     (acc_en),
        .wr_en      (wr_en),
        .hold       (busy),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    assign start_store  = hit_store && !low_vdd;
    assign start_recall = hit_recall;

    op_timer #(
        .STORE_CYCLES  (STORE_CYCLES),
        .RECALL_CYCLES (RECALL_CYCLES),
        .CLEAR_CYCLES  (CLEAR_CYCLES)
    ) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_store  (start_store),
        .start_recall (start_recall),
        .busy         (busy),
        .clr_phase    (clr_phase),
        .xfer_phase   (xfer_phase)
    );

    always_comb begin
        pls_d           = '0;
        pls_d.store_go  = start_store;
        pls_d.recall_go = start_recall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign store_go  = pls_q.store_go;
    assign recall_go = pls_q.recall_go;
    assign ready     = !busy;
    assign rd_allow  = acc_en && !wr_en && !busy;
    assign wr_allow  = acc_en && wr_en && !busy && !low_vdd;
    assign dq_drive  = rd_allow && oe_en;

    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go, recall_go}));

    // R1
    store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> (busy && !$past(busy)));

    // R2
    recall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |-> (clr_phase && !$past(busy)));

    // R7
    lowv_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> !$past(low_vdd));
endmodule

// File: tb/tb_seqdet_top.sv
module tb_seqdet_top;
    localparam int TS = 20;
    localparam int TR = 12;
    localparam int TC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr = '0;
    logic        acc_en = 1'b0, wr_en = 1'b0, oe_en = 1'b0, low_vdd = 1'b0;
    logic        store_go, recall_go, busy, ready, clr_phase, xfer_phase;
    logic        wr_allow, rd_allow, dq_drive;

    int tests = 0, fails = 0;
    int n_store = 0, n_recall = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    seqdet_top #(.STORE_CYCLES(TS), .RECALL_CYCLES(TR), .CLEAR_CYCLES(TC)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .acc_en(acc_en), .wr_en(wr_en),
        .oe_en(oe_en), .low_vdd(low_vdd), .store_go(store_go), .recall_go(recall_go),
        .busy(busy), .ready(ready), .clr_phase(clr_phase), .xfer_phase(xfer_phase),
        .wr_allow(wr_allow), .rd_allow(rd_allow), .dq_drive(dq_drive)
    );

    // behavioural reference: progress count, phase (0 idle,1 store,2 clear,3 xfer), cycles left
    int unsigned prefix[$] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
    int m_ptr = 0, m_ph = 0, m_rem = 0;
    bit m_sg = 0, m_rg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_ph = 0; m_rem = 0; m_sg = 0; m_rg = 0;
        end else begin
            m_sg = 0; m_rg = 0;
            if (m_ph != 0) begin
                m_ptr = 0;
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    if (m_ph == 2) begin m_ph = 3; m_rem = TR - TC; end
                    else m_ph = 0;
                end
            end else if (acc_en) begin
                if (wr_en) m_ptr = 0;
                else if (m_ptr == 5) begin
                    if (addr == 15'h0FC0) begin
                        if (!low_vdd) begin m_sg = 1; m_ph = 1; m_rem = TS; end
                    end else if (addr == 15'h0C63) begin
                        m_rg = 1; m_ph = 2; m_rem = TC;
                    end
                    m_ptr = (addr == prefix[0]) ? 1 : 0;
                end else if (addr == prefix[m_ptr]) m_ptr = m_ptr + 1;
                else m_ptr = (addr == prefix[0]) ? 1 : 0;
            end
        end
    end

    task automatic chk(input string req, input string nm, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit eb = (m_ph != 0);
        bit erd = acc_en && !wr_en && !eb;
        chk("R1", "store_go", store_go, m_sg);
        chk("R2", "recall_go", recall_go, m_rg);
        chk("R5", "busy", busy, eb);
        chk("R5", "ready", ready, !eb);
        chk("R6", "clr_phase", clr_phase, m_ph == 2);
        chk("R6", "xfer_phase", xfer_phase, m_ph == 3);
        chk("R7", "wr_allow", wr_allow, acc_en && wr_en && !eb && !low_vdd);
        chk("R9", "rd_allow", rd_allow, erd);
        chk("R9", "dq_drive", dq_drive, erd && oe_en);
        if (store_go === 1'b1)  n_store++;
        if (recall_go === 1'b1) n_recall++;
    endtask

    task automatic step(input logic [14:0] a, input logic acc, input logic wr, input logic oe);
        @(negedge clk);
        addr = a; acc_en = acc; wr_en = wr; oe_en = oe;
        #1;
        compare_all();
    endtask

    task automatic rd(input logic [14:0] a); step(a, 1'b1, 1'b0, 1'b0); endtask
    task automatic rdo(input logic [14:0] a); step(a, 1'b1, 1'b0, 1'b1); endtask
    task automatic wrc(input logic [14:0] a); step(a, 1'b1, 1'b1, 1'b0); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(15'h0, 1'b0, 1'b0, 1'b0);
    endtask
    task automatic prefix5();
        for (int i = 0; i < 5; i++) rd(prefix[i][14:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0, r0;
        repeat (3) @(posedge clk);
        #1; compare_all();                       // reset state, R5 ready
        chk("R5", "ready_in_reset", ready, 1);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R1: store sequence, output enable low throughout (R3)
        s0 = n_store;
        prefix5(); rd(15'h0FC0); idle(1);
        chk("R1", "store_count", n_store - s0, 1);
        chk("R5", "busy_after_store", busy, 1);
        idle(TS);
        chk("R5", "ready_after_store", ready, 1);

        // R2: recall with output enable high and idle gaps (R3)
        r0 = n_recall;
        for (int i = 0; i < 5; i++) begin rdo(prefix[i][14:0]); idle(2); end
        rdo(15'h0C63); idle(1);
        chk("R2", "recall_count", n_recall - r0, 1);
        idle(TR + 2);

        // R3: write inside a partial match aborts it
        s0 = n_store;
        rd(15'h0E38); rd(15'h31C7); rd(15'h03E0); wrc(15'h3C1F);
        rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0); idle(2);
        chk("R3", "write_abort", n_store - s0, 0);

        // R4: stray head address restarts at step one
        s0 = n_store;
        rd(15'h0E38); rd(15'h31C7); prefix5(); rd(15'h0FC0); idle(1);
        chk("R4", "head_restart", n_store - s0, 1);
        idle(TS + 2);

        // R4: other mismatch drops to zero
        s0 = n_store;
        rd(15'h0E38); rd(15'h31C7); rd(15'h0111);
        rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0); idle(2);
        chk("R4", "mismatch_reset", n_store - s0, 0);

        // R5: a recall sent during store busy time is ignored
        s0 = n_store; r0 = n_recall;
        prefix5(); rd(15'h0FC0);
        prefix5(); rd(15'h0C63); wrc(15'h0001);
        idle(TS + 2);
        chk("R5", "busy_ignores_seq", n_recall - r0, 0);
        chk("R1", "store_once", n_store - s0, 1);

        // R7: low supply blocks store and writes, recall still runs
        @(negedge clk); low_vdd = 1'b1;
        s0 = n_store; r0 = n_recall;
        wrc(15'h0100);
        chk("R7", "wr_blocked", wr_allow, 0);
        prefix5(); rd(15'h0FC0); idle(2);
        chk("R7", "lowv_no_store", n_store - s0, 0);
        chk("R7", "lowv_no_busy", busy, 0);
        prefix5(); rd(15'h0C63); idle(1);
        chk("R7", "lowv_recall", n_recall - r0, 1);
        idle(TR + 2);
        @(negedge clk); low_vdd = 1'b0;

        // R8: repeated recalls
        r0 = n_recall;
        for (int k = 0; k < 3; k++) begin
            prefix5(); rd(15'h0C63); idle(TR + 1);
        end
        chk("R8", "recall_repeat", n_recall - r0, 3);
        wrc(15'h0200);
        chk("R9", "write_allowed_idle", wr_allow, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule